// File: doc/BRIEF.md
# MDIO Station-Management Master

This block issues management frames toward external Ethernet PHYs over a two-wire serial link: a management clock (MDC) that it produces itself, and a bidirectional data line (MDIO) that appears as a data output, an output-enable and a data input. Software programs it through a small register port. One command register holds the PHY address, the register or device address, the operation, the frame style (Clause 22 or Clause 45) and the timing options. A data register supplies write data and the Clause 45 register address, and it receives the read data.

Software sets the go bit in the command register. The block then runs a complete transaction without further help. MDC is derived from the register clock by an even divisor, chosen by a 4-bit code. Each frame can be preceded by idle training clocks and by a preamble of all ones. In Clause 45 mode an address frame is sent before the data frame, unless software asks to skip it. When the transaction ends, the busy flag drops. Without back-to-back mode, a short idle gap on the MDC clock comes before that.

The register port has no back-pressure: a write is accepted or ignored in the cycle it is presented, and reads are combinational. The serial pins are plain control and status signals, with no handshake.

Top module: `mdio_master`

## Requirements
- R1: After reset the command register and the data register read as zero, busy is clear, MDC is low and MDIO is released (output-enable low).
- R2: A write to register select 0 stores the command fields. The fields are: bit 1 Clause 45 enable, bits 3:2 operation (1 write, 2 Clause 45 read with address post-increment, 3 read), bit 4 skip-address, bit 5 back-to-back, bit 6 preamble suppress, bits 11:8 clock-range code, bits 14:12 training count, bits 20:16 register/device address, bits 25:21 PHY address. The fields read back at the same positions, with bit 0 showing busy. If bit 0 is written as 1 and the operation is nonzero, busy sets and a transaction starts. An operation of 0 starts nothing.
- R3: While busy is set, writes to the command register and to the data register (select 1) are ignored.
- R4: Clock-range codes 0 to 7 give MDC divisors 42, 62, 16, 26, 102, 124, 204 and 324. Codes 8 to 15 give 4, 6, 8, 10, 12, 14, 16 and 18. Each MDC cycle is low for half the divisor and then high for half. Busy reads clear D*M+1 clock edges after the edge that captures the command, where D is the divisor and M is the number of MDC cycles in the transaction.
- R5: A Clause 22 frame is sent MSB first as: start 01, op (01 write, 10 read), 5-bit PHY address, 5-bit register address, turnaround 10, then data bits 15:0 of the data register. Operation code 2 without Clause 45 is sent as a read.
- R6: With Clause 45 enabled and skip clear, an address frame is sent first: start 00, op 00, PHY address, device address, turnaround 10, then data register bits 31:16. A data frame follows with start 00 and op 01 (write), 11 (read) or 10 (post-increment read).
- R7: With Clause 45 and skip-address both set, only the data frame is sent.
- R8: Unless preamble suppress is set, each frame is preceded by 32 MDC cycles with MDIO driven to 1.
- R9: Each frame, including a Clause 45 address frame, begins with the programmed number of training MDC cycles, during which MDIO is released.
- R10: In a read data frame, MDIO is released for the turnaround and the 16 data bits. The data bits are sampled on the rising MDC edges. On completion they land in data register bits 15:0, and bits 31:16 are kept.
- R11: Without back-to-back mode, busy stays set for 2 extra MDC cycles, with MDIO released, after the last frame bit. With back-to-back it clears at the end of the last bit.
- R12: Whenever busy is clear, MDC is low and MDIO is released. MDIO output changes only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock, source of MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 command, 1 data |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read select: 0 command, 1 data |
| reg_rdata | output | 32 | Combinational read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 drives the line) |
| mdio_i | input | 1 | MDIO input from the line |

## Verification
Register reads are combinational, so the command fields and the data register are checked in the same cycle as they are selected. A transaction's duration follows from R4. The bench counts clock edges from the edge that captures the command to the first edge after which busy reads low, and expects exactly D*M+1. The serial stream is recorded at each MDC rising edge as driven-0, driven-1 or released, and compared position by position against a frame that the bench builds from the requirements. Read data is presented after each MDC falling edge, so it is stable when the design samples at the next rising edge, and it is read back only once busy has dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int MAX_DIV    = 324;
  localparam int HALF_W     = $clog2(MAX_DIV / 2 + 1);
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DATA_W     = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRAIN,
    ST_PRE,
    ST_FRAME,
    ST_GAP
  } seq_state_e;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] rdev;
    logic [2:0] train;
    logic [3:0] clk_sel;
    logic       psup;
    logic       b2b;
    logic       skip;
    logic [1:0] op;
    logic       c45;
  } mdio_cmd_t;

  function automatic logic [8:0] mdc_divisor(input logic [3:0] sel);
    logic [8:0] d;
    unique case (sel)
      4'd0:    d = 9'd42;
      4'd1:    d = 9'd62;
      4'd2:    d = 9'd16;
      4'd3:    d = 9'd26;
      4'd4:    d = 9'd102;
      4'd5:    d = 9'd124;
      4'd6:    d = 9'd204;
      4'd7:    d = 9'd324;
      default: d = 9'd4 + {4'd0, sel[2:0], 1'b0};
    endcase
    return d;
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] sel,
  output logic       mdc,
  output logic       rise_tick,
  output logic       fall_tick
);

  logic [8:0]        div;
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign div  = mdc_divisor(sel);
  assign half = HALF_W'(div >> 1);
  assign tick = run && (cnt == half - HALF_W'(1));

  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              wsel,
  input  logic [REG_W-1:0]  wdata,
  input  logic              rsel,
  output logic [REG_W-1:0]  rdata,
  input  logic              done,
  input  logic              store_rd,
  input  logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              start,
  output mdio_cmd_t         cmd,
  output logic [DATA_W-1:0] data_lo,
  output logic [DATA_W-1:0] data_hi
);

  mdio_cmd_t new_cmd;

  always_comb begin
    new_cmd.c45     = wdata[1];
    new_cmd.op      = wdata[3:2];
    new_cmd.skip    = wdata[4];
    new_cmd.b2b     = wdata[5];
    new_cmd.psup    = wdata[6];
    new_cmd.clk_sel = wdata[11:8];
    new_cmd.train   = wdata[14:12];
    new_cmd.rdev    = wdata[20:16];
    new_cmd.phy     = wdata[25:21];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      start   <= 1'b0;
      cmd     <= '0;
      data_lo <= '0;
      data_hi <= '0;
    end else begin
      start <= 1'b0;
      if (done) begin
        busy <= 1'b0;
        if (store_rd) data_lo <= rd_word;
      end else if (wr && !busy) begin
        if (!wsel) begin
          cmd <= new_cmd;
          if (wdata[0] && (new_cmd.op != 2'd0)) begin
            busy  <= 1'b1;
            start <= 1'b1;
          end
        end else begin
          data_lo <= wdata[DATA_W-1:0];
          data_hi <= wdata[2*DATA_W-1:DATA_W];
        end
      end
    end
  end

  always_comb begin
    if (rsel) begin
      rdata = REG_W'({data_hi, data_lo});
    end else begin
      rdata = REG_W'({6'd0, cmd.phy, cmd.rdev, 1'b0, cmd.train, cmd.clk_sel,
                      1'b0, cmd.psup, cmd.b2b, cmd.skip, cmd.op, cmd.c45, busy});
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [DATA_W-1:0] c45_word,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              store_rd,
  output logic [DATA_W-1:0] rd_word
);

  localparam int CNT_W    = 6;
  localparam int LAST_BIT = FRAME_BITS - 1;
  localparam int LAST_PRE = PRE_BITS - 1;
  localparam int TA_POS   = FRAME_BITS - DATA_W - 2;
  localparam int DAT_POS  = FRAME_BITS - DATA_W;

  seq_state_e             state, nxt;
  logic [CNT_W-1:0]       cnt, ncnt;
  logic                   cur_addr, naddr;
  logic                   load;
  logic [FRAME_BITS-1:0]  sh, word;
  logic                   is_read, need_addr, rd_frame;
  seq_state_e             first_st;

  assign is_read   = cmd.op[1];
  assign need_addr = cmd.c45 && !cmd.skip;
  assign rd_frame  = is_read && !cur_addr;
  assign run       = (state != ST_IDLE);
  assign store_rd  = done && is_read;

  always_comb begin
    if (cmd.train != 3'd0) first_st = ST_TRAIN;
    else if (!cmd.psup)    first_st = ST_PRE;
    else                   first_st = ST_FRAME;
  end

  always_comb begin
    if (!cmd.c45) begin
      word = {2'b01, (is_read ? 2'b10 : 2'b01), cmd.phy, cmd.rdev, 2'b10, wr_word};
    end else if (naddr) begin
      word = {2'b00, 2'b00, cmd.phy, cmd.rdev, 2'b10, c45_word};
    end else begin
      word = {2'b00, cmd.op, cmd.phy, cmd.rdev, 2'b10, wr_word};
    end
  end

  always_comb begin
    nxt   = state;
    ncnt  = cnt;
    naddr = cur_addr;
    load  = 1'b0;
    done  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          naddr = need_addr;
          nxt   = first_st;
          ncnt  = '0;
          load  = (first_st == ST_FRAME);
        end
      end
      ST_TRAIN: begin
        if (fall_tick) begin
          if (cnt == CNT_W'(cmd.train) - CNT_W'(1)) begin
            nxt  = cmd.psup ? ST_FRAME : ST_PRE;
            ncnt = '0;
            load = cmd.psup;
          end else begin
            ncnt = cnt + CNT_W'(1);
          end
        end
      end
      ST_PRE: begin
        if (fall_tick) begin
          if (cnt == CNT_W'(LAST_PRE)) begin
            nxt  = ST_FRAME;
            ncnt = '0;
            load = 1'b1;
          end else begin
            ncnt = cnt + CNT_W'(1);
          end
        end
      end
      ST_FRAME: begin
        if (fall_tick) begin
          if (cnt == CNT_W'(LAST_BIT)) begin
            ncnt = '0;
            if (cur_addr) begin
              naddr = 1'b0;
              nxt   = first_st;
              load  = (first_st == ST_FRAME);
            end else if (cmd.b2b || (GAP_CYCLES == 0)) begin
              nxt  = ST_IDLE;
              done = 1'b1;
            end else begin
              nxt = ST_GAP;
            end
          end else begin
            ncnt = cnt + CNT_W'(1);
          end
        end
      end
      ST_GAP: begin
        if (fall_tick) begin
          if (cnt == CNT_W'(GAP_CYCLES - 1)) begin
            nxt  = ST_IDLE;
            ncnt = '0;
            done = 1'b1;
          end else begin
            ncnt = cnt + CNT_W'(1);
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_addr <= 1'b0;
      sh       <= '0;
      rd_word  <= '0;
    end else begin
      state    <= nxt;
      cnt      <= ncnt;
      cur_addr <= naddr;
      if (load) begin
        sh <= word;
      end else if ((state == ST_FRAME) && fall_tick) begin
        sh <= {sh[FRAME_BITS-2:0], 1'b0};
      end
      if ((state == ST_FRAME) && rise_tick && rd_frame && (cnt >= CNT_W'(DAT_POS))) begin
        rd_word <= {rd_word[DATA_W-2:0], mdio_i};
      end
    end
  end

  assign mdio_o  = (state == ST_FRAME) ? sh[FRAME_BITS-1] : (state == ST_PRE);
  assign mdio_oe = (state == ST_PRE) ||
                   ((state == ST_FRAME) && !(rd_frame && (cnt >= CNT_W'(TA_POS))));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int GAP_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_wsel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rsel,
  output logic [REG_W-1:0] reg_rdata,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  logic              busy_q;
  logic              start_p;
  mdio_cmd_t         cmd_q;
  logic [DATA_W-1:0] wr_word;
  logic [DATA_W-1:0] c45_word;
  logic              run;
  logic              rise_tick;
  logic              fall_tick;
  logic              done;
  logic              store_rd;
  logic [DATA_W-1:0] rd_word;

  mdio_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .wsel     (reg_wsel),
    .wdata    (reg_wdata),
    .rsel     (reg_rsel),
    .rdata    (reg_rdata),
    .done     (done),
    .store_rd (store_rd),
    .rd_word  (rd_word),
    .busy     (busy_q),
    .start    (start_p),
    .cmd      (cmd_q),
    .data_lo  (wr_word),
    .data_hi  (c45_word)
  );

  mdio_clkgen u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sel       (cmd_q.clk_sel),
    .mdc       (mdc_o),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_p),
    .cmd       (cmd_q),
    .wr_word   (wr_word),
    .c45_word  (c45_word),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .run       (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .store_rd  (store_rd),
    .rd_word   (rd_word)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      busy,
  input logic      mdc_o,
  input logic      mdio_o,
  input logic      mdio_oe,
  input logic      reg_wr,
  input logic      reg_wsel,
  input logic      go_bit,
  input mdio_cmd_t cmd_q
);

  logic [8:0] hi_len;
  logic [8:0] div_now;

  assign div_now = mdc_divisor(cmd_q.clk_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len <= '0;
    else if (mdc_o) hi_len <= hi_len + 9'd1;
    else            hi_len <= '0;
  end

  assert_idle_mdc_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_o);

  assert_idle_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_mdio_steady_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));

  assert_busy_needs_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_wsel && go_bit));

  assert_cmd_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));

  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc_o) |-> (hi_len == {1'b0, div_now[8:1]}));

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_q),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .reg_wr   (reg_wr),
  .reg_wsel (reg_wsel),
  .go_bit   (reg_wdata[0]),
  .cmd_q    (cmd_q)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  typedef struct packed {
    logic        c45;
    logic [1:0]  op;
    logic        skip;
    logic        b2b;
    logic        psup;
    logic [3:0]  sel;
    logic [2:0]  train;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] ra;
    logic [15:0] rd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 4'd8,  3'd0, 5'h11, 5'h0A, 16'hA5C3, 16'h0000, 16'h0000},
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 4'd9,  3'd2, 5'h03, 5'h1F, 16'h0000, 16'h0000, 16'h3C5A},
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 4'd10, 3'd0, 5'h1E, 5'h07, 16'hBEEF, 16'h1234, 16'h0000},
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 4'd2,  3'd1, 5'h01, 5'h03, 16'h0000, 16'h0000, 16'h8001},
    '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 4'd11, 3'd2, 5'h15, 5'h01, 16'h0000, 16'h00FF, 16'h7E0F},
    '{1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 4'd0,  3'd0, 5'h00, 5'h10, 16'h5AA5, 16'h0000, 16'h0000},
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 4'd7,  3'd0, 5'h1F, 5'h1F, 16'h0000, 16'h0000, 16'hC3A5},
    '{1'b0, 2'd2, 1'b0, 1'b1, 1'b1, 4'd12, 3'd0, 5'h08, 5'h02, 16'h0000, 16'h0000, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_wsel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rsel = 1'b0;
  logic [31:0] reg_rdata;
  logic        mdc_o, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int nrise = 0;
  int exp_n = 0;
  int cap   [0:255];
  int exp_s [0:255];
  logic in_bits [0:255];

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wsel(reg_wsel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(posedge mdc_o) begin
    if (nrise < 256) cap[nrise] = mdio_oe ? int'(mdio_o) : 2;
    nrise++;
  end
  always @(negedge mdc_o) begin
    if (nrise < 256) mdio_i = in_bits[nrise];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int divisor(input logic [3:0] s);
    int t [0:7] = '{42, 62, 16, 26, 102, 124, 204, 324};
    if (s < 8) return t[s];
    return 4 + 2 * (int'(s) - 8);
  endfunction

  function automatic logic [31:0] cmd_word(input vec_t v, input bit go);
    return {6'd0, v.phy, v.rg, 1'b0, v.train, v.sel, 1'b0, v.psup, v.b2b,
            v.skip, v.op, v.c45, go};
  endfunction

  task automatic build(input vec_t v);
    int n;
    int frames;
    bit rd;
    bit af;
    logic [31:0] w;
    n = 0;
    rd = v.op[1];
    frames = (v.c45 && !v.skip) ? 2 : 1;
    for (int i = 0; i < 256; i++) in_bits[i] = 1'b1;
    for (int f = 0; f < frames; f++) begin
      af = (frames == 2) && (f == 0);
      if (!v.c45)  w = {2'b01, (rd ? 2'b10 : 2'b01), v.phy, v.rg, 2'b10, v.wd};
      else if (af) w = {2'b00, 2'b00, v.phy, v.rg, 2'b10, v.ra};
      else         w = {2'b00, v.op, v.phy, v.rg, 2'b10, v.wd};
      for (int t = 0; t < int'(v.train); t++) begin exp_s[n] = 2; n++; end
      if (!v.psup) for (int p = 0; p < 32; p++) begin exp_s[n] = 1; n++; end
      for (int b = 0; b < 32; b++) begin
        if (rd && !af && b >= 14) begin
          exp_s[n] = 2;
          if (b >= 16) in_bits[n] = v.rd[31-b];
        end else begin
          exp_s[n] = int'(w[31-b]);
        end
        n++;
      end
    end
    if (!v.b2b) for (int g = 0; g < 2; g++) begin exp_s[n] = 2; n++; end
    exp_n = n;
  endtask

  task automatic reg_write(input bit s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wsel = s; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit meddle);
    int c0;
    int lat;
    int bad;
    int first;
    bit hung;
    build(v);
    nrise = 0;
    for (int i = 0; i < 256; i++) cap[i] = -1;
    mdio_i = in_bits[0];
    reg_write(1'b1, {v.ra, v.wd});
    reg_write(1'b0, cmd_word(v, 1'b1));
    c0 = cyc;
    if (meddle) begin
      reg_write(1'b0, 32'h03E0_0F07);
      reg_write(1'b1, 32'h0000_0000);
    end
    hung = 1'b0;
    reg_rsel = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (!reg_rdata[0]) break;
      if (cyc - c0 > 60000) begin hung = 1'b1; break; end
    end
    lat = cyc - c0;
    chk(!hung && lat == divisor(v.sel) * exp_n + 1, "R4", "busy-clear latency",
        lat, divisor(v.sel) * exp_n + 1);
    chk(nrise == exp_n, "R9 R8 R11", "MDC cycle count", nrise, exp_n);
    bad = 0; first = -1;
    for (int i = 0; i < exp_n && i < 256; i++)
      if (cap[i] != exp_s[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) first = 0;
    chk(bad == 0, v.c45 ? "R6 R7 R10" : "R5 R10", "MDIO stream", cap[first], exp_s[first]);
    chk(!mdc_o && !mdio_oe, "R12", "idle pins", {mdc_o, mdio_oe}, 0);
    chk(reg_rdata == cmd_word(v, 1'b0), meddle ? "R3" : "R2", "command readback",
        reg_rdata, cmd_word(v, 1'b0));
    reg_rsel = 1'b1;
    #1;
    if (v.op[1])
      chk(reg_rdata == {v.ra, v.rd}, "R10", "read data", reg_rdata, {v.ra, v.rd});
    else
      chk(reg_rdata == {v.ra, v.wd}, meddle ? "R3" : "R5", "data kept", reg_rdata, {v.ra, v.wd});
    reg_rsel = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(reg_rdata == 32'd0, "R1", "command after reset", reg_rdata, 0);
    chk(!mdc_o && !mdio_oe, "R1", "pins after reset", {mdc_o, mdio_oe}, 0);
    rst_n = 1'b1;
    reg_rsel = 1'b1;
    #1;
    chk(reg_rdata == 32'd0, "R1", "data after reset", reg_rdata, 0);
    reg_rsel = 1'b0;
    repeat (2) @(posedge clk);

    for (int k = 0; k < NVEC; k++) run_vec(VECS[k], 1'b0);

    // R3: writes while busy are ignored
    run_vec(VECS[0], 1'b1);

    // R2: operation 0 starts nothing
    r0 = nrise;
    reg_write(1'b0, 32'h0022_0801);
    repeat (40) @(posedge clk);
    #1;
    chk(reg_rdata == 32'h0022_0800, "R2", "op 0 no busy", reg_rdata, 32'h0022_0800);
    chk(nrise == r0, "R2", "op 0 no MDC", nrise, r0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule